// File: doc/BRIEF.md
# Flag-Handshake Character I/O Port

This block sits between a processor and two slow character devices: a keyboard-side source and a printer-side sink. Each direction has one 8-bit holding register and a single ready flag. Together they work as a one-deep mailbox. A flag locks its register until the other side has taken the character. The block does not throttle a fast processor; the flags let it match its pace to devices that run far slower.

The input flag rests at 0. A device strobe loads a character and raises the flag. A processor read takes the character onto the accumulator bus and drops the flag.

The output flag rests at 1, meaning the printer is idle. A processor write loads the output register, drops the flag and sends a one-cycle valid pulse to the printer. The printer raises the flag again with a done strobe once it has finished. An enable bit gates an interrupt request that goes up whenever either flag asks for attention.

Top module: `char_io_port`

## Requirements
- R1: After a synchronous active-high reset, the input flag is 0, the output flag is 1, the output register is 0, out_valid is 0 and the interrupt enable is 0, so irq is 0.
- R2: A kb_stb while the input flag is 0 loads kb_data into the input register with bit 7 forced to 0. The input flag reads 1 from the next cycle.
- R3: While the input flag is 1, kb_stb is ignored. The register keeps its character, and a later read returns the first character.
- R4: A cpu_rd while the input flag is 1 presents the input register on rd_data in the same cycle. The input flag reads 0 from the next cycle.
- R5: A cpu_rd while the input flag is 0 has no effect on either flag, and rd_data is 0 whenever no read is accepted.
- R6: A cpu_wr while the output flag is 1 loads wr_data into out_data. From the next cycle the output flag is 0, and out_valid is high for exactly that one cycle.
- R7: A cpu_wr while the output flag is 0 is ignored. out_data keeps its value and no out_valid pulse appears.
- R8: prn_done while the output flag is 0 sets the flag to 1 from the next cycle. prn_done while the flag is already 1 has no effect.
- R9: irq equals the interrupt enable ANDed with the OR of the two flags. The enable takes ie_din on a cycle with ie_we high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_stb | input | 1 | One-cycle strobe: device offers a character |
| kb_data | input | 8 | Character from the input device |
| cpu_rd | input | 1 | Processor request to take the input character |
| rd_data | output | 8 | Accumulator bus; input register during an accepted read, else 0 |
| cpu_wr | input | 1 | Processor request to send a character |
| wr_data | input | 8 | Accumulator value to send |
| out_data | output | 8 | Output register toward the printer |
| out_valid | output | 1 | One-cycle pulse when out_data has been loaded |
| prn_done | input | 1 | One-cycle strobe: printer finished the character |
| ie_we | input | 1 | Write strobe for the interrupt enable |
| ie_din | input | 1 | New interrupt enable value |
| in_flag | output | 1 | Input ready flag (1 = character waiting) |
| out_flag | output | 1 | Output ready flag (1 = printer idle) |
| irq | output | 1 | Interrupt request |

## Verification
The inline assertions check the following on every clock:
- the input register stays frozen while its flag is up and no read is accepted;
- the output register and flag stay put while the printer is busy;
- an accepted read clears the input flag;
- an accepted write loads the output register and pulses valid;
- out_valid is never high while the output flag is 1.

Other behaviour needs the bench's directed scenarios:
- that a rejected character is truly lost;
- that the value a later read returns is the first character;
- the reset state;
- the gating of irq by the enable.

// File: rtl/char_io_port.sv
module char_io_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kb_stb,
  input  logic [DW-1:0] kb_data,
  input  logic          cpu_rd,
  output logic [DW-1:0] rd_data,
  input  logic          cpu_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          prn_done,
  input  logic          ie_we,
  input  logic          ie_din,
  output logic          in_flag,
  output logic          out_flag,
  output logic          irq
);

  logic [DW-1:0] in_reg;
  logic          ie;

  wire take_in  = kb_stb && !in_flag;
  wire rd_ok    = cpu_rd && in_flag;
  wire wr_ok    = cpu_wr && out_flag;
  wire done_ok  = prn_done && !out_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg  <= '0;
      in_flag <= 1'b0;
    end else if (take_in) begin
      in_reg  <= {1'b0, kb_data[DW-2:0]};
      in_flag <= 1'b1;
    end else if (rd_ok) begin
      in_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_flag  <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      out_valid <= wr_ok;
      if (wr_ok) begin
        out_data <= wr_data;
        out_flag <= 1'b0;
      end else if (done_ok) begin
        out_flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ie <= 1'b0;
    else if (ie_we) ie <= ie_din;
  end

  assign rd_data = rd_ok ? in_reg : '0;
  assign irq     = ie && (in_flag || out_flag);

  p_in_load_r2: assert property (@(posedge clk) disable iff (rst)
    (kb_stb && !in_flag) |=> (in_flag && !in_reg[DW-1]));

  p_in_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (in_flag && !cpu_rd) |=> (in_flag && $stable(in_reg)));

  p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && in_flag) |=> !in_flag);

  p_out_load_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && out_flag) |=> (!out_flag && out_valid && out_data == $past(wr_data)));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!out_flag && !prn_done) |=> (!out_flag && !out_valid && $stable(out_data)));

  p_done_set_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_flag && prn_done) |=> out_flag);

  p_valid_busy_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_flag);

endmodule

// File: tb/char_io_port_tb_top.sv
module char_io_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_stb = 0, cpu_rd = 0, cpu_wr = 0, prn_done = 0, ie_we = 0, ie_din = 0;
  logic [7:0] kb_data = 0, wr_data = 0;
  logic [7:0] rd_data, out_data;
  logic       out_valid, in_flag, out_flag, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  char_io_port dut_i (
    .clk(clk), .rst(rst), .kb_stb(kb_stb), .kb_data(kb_data), .cpu_rd(cpu_rd),
    .rd_data(rd_data), .cpu_wr(cpu_wr), .wr_data(wr_data), .out_data(out_data),
    .out_valid(out_valid), .prn_done(prn_done), .ie_we(ie_we), .ie_din(ie_din),
    .in_flag(in_flag), .out_flag(out_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    kb_stb = 0; cpu_rd = 0; cpu_wr = 0; prn_done = 0; ie_we = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle(); step(); step(); rst = 0;
    chk("R1 in_flag", in_flag, 0);
    chk("R1 out_flag", out_flag, 1);
    chk("R1 out_data", out_data, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_input_path();
    kb_stb = 1; kb_data = 8'hC1; step(); idle();
    chk("R2 in_flag set", in_flag, 1);
    cpu_rd = 1; #1;
    chk("R2 msb cleared via R4 read", rd_data, 8'h41);
    step(); idle();
    chk("R4 in_flag cleared", in_flag, 0);
    chk("R5 rd_data idle", rd_data, 0);
  endtask

  task automatic t_input_lock();
    kb_stb = 1; kb_data = 8'h33; step();
    kb_data = 8'h55; step(); idle();
    chk("R3 flag still set", in_flag, 1);
    cpu_rd = 1; kb_stb = 1; kb_data = 8'h66; #1;
    chk("R3 first char kept", rd_data, 8'h33);
    step(); idle();
    chk("R3 strobe during read dropped", in_flag, 0);
  endtask

  task automatic t_read_empty();
    cpu_rd = 1; #1;
    chk("R5 rd_data on empty", rd_data, 0);
    step(); idle();
    chk("R5 in_flag unchanged", in_flag, 0);
    chk("R5 out_flag unchanged", out_flag, 1);
  endtask

  task automatic t_output_path();
    cpu_wr = 1; wr_data = 8'h5A; step(); idle();
    chk("R6 out_data", out_data, 8'h5A);
    chk("R6 out_valid", out_valid, 1);
    chk("R6 out_flag", out_flag, 0);
    step();
    chk("R6 valid one cycle", out_valid, 0);
  endtask

  task automatic t_output_busy();
    cpu_wr = 1; wr_data = 8'hA7; step(); idle();
    chk("R7 out_data kept", out_data, 8'h5A);
    chk("R7 no valid", out_valid, 0);
    chk("R7 flag still busy", out_flag, 0);
  endtask

  task automatic t_done();
    prn_done = 1; step(); idle();
    chk("R8 flag set", out_flag, 1);
    prn_done = 1; step(); idle();
    chk("R8 extra done no effect", out_flag, 1);
    chk("R8 out_data intact", out_data, 8'h5A);
    cpu_wr = 1; wr_data = 8'h12; step(); idle();
    chk("R8 write after done", out_data, 8'h12);
  endtask

  task automatic t_irq();
    chk("R9 irq off while disabled", irq, 0);
    ie_we = 1; ie_din = 1; step(); idle();
    chk("R9 both flags low", irq, 0);
    kb_stb = 1; kb_data = 8'h20; step(); idle();
    chk("R9 input flag irq", irq, 1);
    cpu_rd = 1; step(); idle();
    chk("R9 irq drops", irq, 0);
    prn_done = 1; step(); idle();
    chk("R9 output flag irq", irq, 1);
    ie_we = 1; ie_din = 0; step(); idle();
    chk("R9 disabled masks", irq, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_input_path();
    t_input_lock();
    t_read_empty();
    t_output_path();
    t_output_busy();
    t_done();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule